// File: doc/BRIEF.md
# Fall-Through Handshake FIFO

This block is a small first-in/first-out buffer for passing words between two agents that run on one system clock but produce and consume at unrelated moments. The producer places a word on the data input and raises a one-cycle push strobe whenever the space flag is high. The consumer always sees the oldest stored word on the data output, qualified by a data-valid flag. It raises a one-cycle pop strobe to discard that word and bring up the next one.

The storage is a register file addressed by a write pointer and a read pointer, each one bit wider than the address so that full and empty can be told apart. A word pushed into an empty buffer reaches the output on the next clock with no pop needed (fall-through). The two flags depend only on registered state, so one instance's data-valid flag can drive the next instance's push strobe and its space flag can drive the previous instance's pop strobe. Several instances can also be placed side by side, with their flags ANDed, to widen the word. An asynchronous active-low master reset empties the buffer. An optional output enable takes the data output off the bus.

Top module: `ft_fifo`

## Requirements
- R1: While and after master reset (`mrst_n` low), `in_rdy` is 1, `out_rdy` is 0 and `q` is all zeros (with `oe` high).
- R2: `in_rdy` is 0 exactly when DEPTH words are held. A push without a pop while `in_rdy` is 0 is ignored and does not alter the stored words.
- R3: `out_rdy` is 1 exactly when at least one word is held. While it is 0, `q` reads all zeros (with `oe` high), and a pop is ignored.
- R4: A push into an empty buffer makes `out_rdy` 1, with `q` equal to the pushed word, on the clock edge that accepts the push.
- R5: Words leave in the order they were accepted. A pop replaces `q` with the next older word on the same edge, and `q` holds steady while no pop occurs.
- R6: A push and a pop on the same edge with at least one word held leave the occupancy unchanged. This includes the full case, where both are accepted. On an empty buffer only the push takes effect.
- R7: With HAS_OE set and `oe` low, `q` carries no stored data (high impedance). The flags and the stored words are unaffected, and raising `oe` again shows the same head word.
- R8: Pulling `mrst_n` low while words are held discards them all, and the buffer returns to the state in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| mrst_n | input | 1 | Asynchronous active-low master reset |
| shin | input | 1 | Push strobe, one cycle per word |
| din | input | W | Word to push |
| in_rdy | output | 1 | Space available; low when full |
| shout | input | 1 | Pop strobe, one cycle per word |
| oe | input | 1 | Output enable for `q` (ignored when HAS_OE is 0) |
| q | output | W | Oldest stored word, zero when empty, high impedance when disabled |
| out_rdy | output | 1 | Valid word on `q`; low when empty |

## Verification
A wrong pointer or wrap bit shows at the ports within one clock of the faulty update. A flag that disagrees with the number of words accepted and removed is visible at once. A pointer that skipped or repeated a slot shows on `q` at the next pop, as a word out of order or a word seen twice. The full and empty boundaries are stressed by filling all DEPTH slots, pushing into a full buffer with and without a pop, and popping an empty buffer. A complete drain afterwards shows whether any word was lost, duplicated or overwritten.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10,
      OP_BOTH = 2'b11
   } fifo_op_e;

   function automatic bit is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/ft_fifo_ptr.sv
module ft_fifo_ptr #(
   parameter int AW = 6
) (
   input  logic        clk,
   input  logic        mrst_n,
   input  logic        adv,
   output logic [AW:0] ptr
);
   logic [AW:0] ptr_q;

   always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n)  ptr_q <= '0;
      else if (adv) ptr_q <= ptr_q + 1'b1;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/ft_fifo_store.sv
module ft_fifo_store #(
   parameter int W     = 4,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(g))) cell_q <= wdata;
      end
      assign cells[g] = cell_q;
   end

   always_comb rdata = cells[raddr];
endmodule

// File: rtl/ft_fifo_status.sv
module ft_fifo_status #(
   parameter int AW = 6
) (
   input  logic [AW:0] wr_ptr,
   input  logic [AW:0] rd_ptr,
   output logic        full,
   output logic        empty
);
   logic [AW:0] level;

   always_comb begin
      level = wr_ptr - rd_ptr;
      full  = level[AW];
      empty = (level == '0);
   end
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
   import ft_fifo_pkg::*;
#(
   parameter int W      = 4,
   parameter int DEPTH  = 64,
   parameter bit HAS_OE = 1'b1,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         mrst_n,
   input  logic         shin,
   input  logic [W-1:0] din,
   output logic         in_rdy,
   input  logic         shout,
   input  logic         oe,
   output logic [W-1:0] q,
   output logic         out_rdy
);
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("ft_fifo: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("ft_fifo: W must be at least 1");
   end

   logic [AW:0]  wr_ptr, rd_ptr;
   logic         full, empty;
   logic         acc_wr, acc_rd;
   logic [W-1:0] head;
   fifo_op_e     op;

   always_comb begin
      op     = fifo_op_e'({shout, shin});
      acc_wr = 1'b0;
      acc_rd = 1'b0;
      unique case (op)
         OP_PUSH: acc_wr = !full;
         OP_POP:  acc_rd = !empty;
         OP_BOTH: begin
            acc_rd = !empty;
            acc_wr = 1'b1;        // full implies non-empty, so a slot frees
         end
         default: ;
      endcase
   end

   ft_fifo_ptr #(.AW(AW)) u_wptr (
      .clk(clk), .mrst_n(mrst_n), .adv(acc_wr), .ptr(wr_ptr)
   );

   ft_fifo_ptr #(.AW(AW)) u_rptr (
      .clk(clk), .mrst_n(mrst_n), .adv(acc_rd), .ptr(rd_ptr)
   );

   ft_fifo_status #(.AW(AW)) u_stat (
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty)
   );

   ft_fifo_store #(.W(W), .DEPTH(DEPTH)) u_mem (
      .clk(clk),
      .we(acc_wr),
      .waddr(wr_ptr[AW-1:0]),
      .wdata(din),
      .raddr(rd_ptr[AW-1:0]),
      .rdata(head)
   );

   assign in_rdy  = !full;
   assign out_rdy = !empty;

   if (HAS_OE) begin : g_oe
      assign q = oe ? (empty ? '0 : head) : {W{1'bz}};
   end else begin : g_no_oe
      logic oe_unused;
      assign oe_unused = oe;
      assign q = empty ? '0 : head;
   end
endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
   parameter int W      = 4,
   parameter int DEPTH  = 64,
   parameter bit HAS_OE = 1'b1,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input logic         clk,
   input logic         mrst_n,
   input logic         shin,
   input logic [W-1:0] din,
   input logic         in_rdy,
   input logic         shout,
   input logic         oe,
   input logic [W-1:0] q,
   input logic         out_rdy
);
   logic [CW-1:0] occ;
   logic          take_in, take_out, drv;

   assign take_out = shout && out_rdy;
   assign take_in  = shin && (in_rdy || take_out);
   assign drv      = HAS_OE ? oe : 1'b1;

   always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) occ <= '0;
      else         occ <= occ + CW'(take_in) - CW'(take_out);
   end

   assert_reset_flags_R1: assert property (@(posedge clk)
      !mrst_n |-> (in_rdy && !out_rdy));

   assert_space_flag_R2: assert property (@(posedge clk) disable iff (!mrst_n)
      in_rdy == (occ != CW'(DEPTH)));

   assert_valid_flag_R3: assert property (@(posedge clk) disable iff (!mrst_n)
      out_rdy == (occ != '0));

   assert_zero_when_empty_R3: assert property (@(posedge clk) disable iff (!mrst_n)
      (!out_rdy && drv) |-> (q == '0));

   assert_fall_through_R4: assert property (@(posedge clk) disable iff (!mrst_n)
      (!out_rdy && shin) |=> (out_rdy && (!drv || q == $past(din))));

   assert_head_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n)
      (out_rdy && !shout && drv) |=> (!drv || $stable(q)));

   assert_both_keeps_level_R6: assert property (@(posedge clk) disable iff (!mrst_n)
      (shin && shout && out_rdy) |=> ($stable(in_rdy) && out_rdy));
endmodule

bind ft_fifo ft_fifo_chk #(.W(W), .DEPTH(DEPTH), .HAS_OE(HAS_OE)) u_chk (
   .clk(clk), .mrst_n(mrst_n), .shin(shin), .din(din), .in_rdy(in_rdy),
   .shout(shout), .oe(oe), .q(q), .out_rdy(out_rdy)
);

// File: tb/ft_fifo_tb_top.sv
module ft_fifo_tb_top;
   localparam int W     = 4;
   localparam int DEPTH = 64;
   localparam int NV    = 10;

   logic         clk = 1'b0;
   logic         mrst_n = 1'b0;
   logic         shin = 1'b0;
   logic         shout = 1'b0;
   logic         oe = 1'b1;
   logic [W-1:0] din = '0;
   logic         in_rdy, out_rdy;
   logic [W-1:0] q;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;
   logic [W-1:0] mq [$];

   always #5 clk = ~clk;

   ft_fifo #(.W(W), .DEPTH(DEPTH), .HAS_OE(1'b1)) dut_i (
      .clk(clk), .mrst_n(mrst_n), .shin(shin), .din(din), .in_rdy(in_rdy),
      .shout(shout), .oe(oe), .q(q), .out_rdy(out_rdy)
   );

   // vector: [13] push, [12] pop, [11:8] din, [7] exp in_rdy,
   //         [6] exp out_rdy, [3:0] exp q  (bits 5:4 unused)
   localparam logic [13:0] VEC [NV] = '{
      14'b1_0_0101_1_1_00_0101, // R4 push into empty falls through
      14'b1_0_1010_1_1_00_0101, // R5 head unchanged by push
      14'b1_0_0011_1_1_00_0101,
      14'b0_1_0000_1_1_00_1010, // R5 pop advances
      14'b1_1_0111_1_1_00_0011, // R6 both on non-empty
      14'b0_1_0000_1_1_00_0111,
      14'b0_1_0000_1_0_00_0000, // R3 drained
      14'b0_1_0000_1_0_00_0000, // R3 pop on empty ignored
      14'b1_1_1001_1_1_00_1001, // R6 both on empty: push only
      14'b0_1_0000_1_0_00_0000
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic si, input logic so, input logic [W-1:0] d);
      shin = si; shout = so; din = d;
      @(posedge clk);
      #1;
      shin = 1'b0; shout = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in_rdy in reset", 8'(in_rdy), 8'd1);
      check("R1 out_rdy in reset", 8'(out_rdy), 8'd0);
      check("R1 q in reset", 8'(q), 8'd0);
      mrst_n = 1'b1;
      @(negedge clk);
      check("R1 q after reset", 8'(q), 8'd0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][13], VEC[i][12], VEC[i][11:8]);
         check($sformatf("R4/R5/R6/R3 vec%0d in_rdy", i), 8'(in_rdy), 8'(VEC[i][7]));
         check($sformatf("R4/R5/R6/R3 vec%0d out_rdy", i), 8'(out_rdy), 8'(VEC[i][6]));
         check($sformatf("R4/R5/R6/R3 vec%0d q", i), 8'(q), 8'(VEC[i][3:0]));
      end

      // R2: fill every slot
      for (int i = 1; i <= DEPTH; i++) begin
         if (i == DEPTH) check("R2 space before last", 8'(in_rdy), 8'd1);
         step(1'b1, 1'b0, W'(i));
         mq.push_back(W'(i));
      end
      check("R2 full flag", 8'(in_rdy), 8'd0);
      step(1'b1, 1'b0, 4'hF);           // ignored
      check("R2 push on full ignored, head", 8'(q), 8'(mq[0]));
      check("R2 still full", 8'(in_rdy), 8'd0);

      // R6: push and pop together while full
      step(1'b1, 1'b1, 4'hE);
      void'(mq.pop_front());
      mq.push_back(4'hE);
      check("R6 full both keeps full", 8'(in_rdy), 8'd0);
      check("R6 full both advances head", 8'(q), 8'(mq[0]));

      // drain and confirm order (R5, R2)
      for (int i = 0; i < DEPTH; i++) begin
         check($sformatf("R5 drain word %0d", i), 8'(q), 8'(mq[0]));
         void'(mq.pop_front());
         step(1'b0, 1'b1, '0);
      end
      check("R3 empty after drain", 8'(out_rdy), 8'd0);
      check("R2 space after drain", 8'(in_rdy), 8'd1);

      // R7: output enable
      step(1'b1, 1'b0, 4'h6);
      oe = 1'b0;
      #1;
      checks++;
      if (q === 4'h6) begin
         failures++;
         $display("FAIL R7 q with oe low actual=%0h expected=not 6", q);
      end
      check("R7 out_rdy with oe low", 8'(out_rdy), 8'd1);
      @(negedge clk);
      oe = 1'b1;
      #1;
      check("R7 head kept after oe", 8'(q), 8'h6);
      @(negedge clk);

      // R8: reset with contents
      step(1'b1, 1'b0, 4'h2);
      step(1'b1, 1'b0, 4'h3);
      mrst_n = 1'b0;
      #1;
      check("R8 out_rdy after mid reset", 8'(out_rdy), 8'd0);
      check("R8 in_rdy after mid reset", 8'(in_rdy), 8'd1);
      check("R8 q after mid reset", 8'(q), 8'd0);
      @(negedge clk);
      mrst_n = 1'b1;
      @(negedge clk);
      step(1'b1, 1'b0, 4'hC);
      check("R8 fresh word after reset", 8'(q), 8'hC);
      step(1'b0, 1'b1, '0);
      check("R8 empty again", 8'(out_rdy), 8'd0);

      finish_run();
   end
endmodule